// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller

A general-purpose I/O peripheral that sits on a simple single-cycle register bus. It holds an output latch and a direction register, and it drives an output-enable and an output value for every pad. It samples the pad inputs through a two-flop synchroniser so that software can read them. The number of lines equals the register width, which can be 8, 16, 32 or 64 bits.

Software can change the outputs in three ways. It can load the whole latch through the data word. It can also write a mask to the set word, which raises the marked bits, or to the clear word, which drops the marked bits. Each of these needs only one bus write, and no read-modify-write sequence. Three compile-time options are available. The first inverts the meaning of the direction bits. The second lets the set word read back the latch. The third reverses the mapping between lines and register bits.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: After reset the output latch is zero, every line is an input (pad_oe all zero, pad_out all zero) and bus_rdata is zero.
- R2: A write to word 0 (address bits [3:2] = 0) loads the whole output latch from bus_wdata on that clock edge.
- R3: A write to word 1 (address 0x4) sets each latch bit whose bus_wdata bit is 1 and leaves the other bits unchanged.
- R4: A write to word 2 (address 0x8) clears each latch bit whose bus_wdata bit is 1 and leaves the other bits unchanged. A read of word 2 returns zero.
- R5: With normal polarity (DIR_INVERT=0), a 1 in the direction word (address 0xC) makes the line an output. The direction word reads back the stored value, and its reset value is all zeros.
- R6: With inverted polarity (DIR_INVERT=1), a 1 in the direction word makes the line an input. The reset value is all ones, so every line is an input.
- R7: A read of word 0 returns the latch bit for each output line. For each input line it returns the pad value, which passes through two synchronising flops. A pad change made before edge k is first seen by a read issued at edge k+2. Read data appears one cycle after bus_ren and holds until the next read.
- R8: A read of word 1 returns the output latch when SET_READBACK=1, and zero otherwise.
- R9: With REVERSE_BITS=1, line n maps to register bit WIDTH-1-n. Otherwise line n maps to bit n.
- R10: When a write and a read occur in the same cycle, the read returns the state from before the write.
- R11: pad_out[n] is 1 only while line n is an output, and it then equals its latch bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Registered read data |
| pad_in | input | WIDTH | Pad input levels, indexed by line |
| pad_oe | output | WIDTH | Pad output enables, indexed by line |
| pad_out | output | WIDTH | Pad output values, indexed by line |

## Verification
Two pairs of events can fall in the same cycle. In the first, a bus write and a bus read occur together. In the second, a pad input changes in the cycle a data read samples it. The bench issues a data write and a data read on the same edge and expects the old latch value, followed by the new value on the next read. It also changes the pads in the same cycle as three back-to-back reads, and expects the new value only on the third read. A random phase then mixes every word, strobe combination and pad pattern. A behavioural model judges each clock for both a default instance and an 8-bit instance that has every option enabled.

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl #(
  parameter int WIDTH        = 32,
  parameter int ADDR_W       = 4,
  parameter bit DIR_INVERT   = 1'b0,
  parameter bit REVERSE_BITS = 1'b0,
  parameter bit SET_READBACK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_ren,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out
);
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_SET  = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;
  localparam logic [1:0] SEL_DIR  = 2'd3;
  localparam logic [WIDTH-1:0] DIR_RST = DIR_INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
    $error("mmio_gpio_ctrl: WIDTH must be 8, 16, 32 or 64");
  end
  if (ADDR_W < 4) begin : g_bad_addr
    $error("mmio_gpio_ctrl: ADDR_W must be at least 4");
  end

  logic [WIDTH-1:0] out_latch, dir_q, sync1, sync2, oe_reg, pin_reg, rd_next;
  logic [1:0]       sel;
  logic             unused_addr;

  assign sel         = bus_addr[3:2];
  assign unused_addr = ^bus_addr;
  assign oe_reg      = DIR_INVERT ? ~dir_q : dir_q;

  for (genvar n = 0; n < WIDTH; n++) begin : g_line
    localparam int B = REVERSE_BITS ? WIDTH - 1 - n : n;
    assign pad_oe[n]  = oe_reg[B];
    assign pad_out[n] = out_latch[B] & oe_reg[B];
    assign pin_reg[B] = sync2[n];
  end

  always_comb begin
    case (sel)
      SEL_DATA: rd_next = (pin_reg & ~oe_reg) | (out_latch & oe_reg);
      SEL_SET:  rd_next = SET_READBACK ? out_latch : '0;
      SEL_CLR:  rd_next = '0;
      default:  rd_next = dir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_latch <= '0;
      dir_q     <= DIR_RST;
      sync1     <= '0;
      sync2     <= '0;
      bus_rdata <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      if (bus_ren) bus_rdata <= rd_next;
      if (bus_wen) begin
        case (sel)
          SEL_DATA: out_latch <= bus_wdata;
          SEL_SET:  out_latch <= out_latch | bus_wdata;
          SEL_CLR:  out_latch <= out_latch & ~bus_wdata;
          default:  dir_q     <= bus_wdata;
        endcase
      end
    end
  end

  a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && sel == SEL_DATA) |=> out_latch == $past(bus_wdata));

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && sel == SEL_SET) |=>
      ((out_latch & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((out_latch & ~$past(bus_wdata)) == ($past(out_latch) & ~$past(bus_wdata))));

  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && sel == SEL_CLR) |=>
      ((out_latch & $past(bus_wdata)) == '0) &&
      ((out_latch & ~$past(bus_wdata)) == ($past(out_latch) & ~$past(bus_wdata))));

  a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && sel == SEL_CLR) |=> bus_rdata == '0);

  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |=> $stable(bus_rdata));

  a_r11_no_drive_on_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
endmodule

// File: tb/test_mmio_gpio_ctrl.sv
module gpio_ref_model #(
  parameter int W   = 32,
  parameter bit INV = 1'b0,
  parameter bit REV = 1'b0,
  parameter bit RB  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   addr,
  input  logic         wen,
  input  logic         ren,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad,
  output logic [W-1:0] e_rdata,
  output logic [W-1:0] e_oe,
  output logic [W-1:0] e_out
);
  logic [W-1:0] latch, dirv;
  logic [W-1:0] hist[$];

  function automatic int bit_of(int n);
    return REV ? W - 1 - n : n;
  endfunction

  function automatic bit is_out(logic [W-1:0] d, int b);
    return INV ? !d[b] : d[b];
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] rv, pinv;
    if (!rst_n) begin
      latch   = '0;
      dirv    = INV ? '1 : '0;
      e_rdata = '0;
      hist.delete();
      hist.push_back('0);
      hist.push_back('0);
    end else begin
      for (int n = 0; n < W; n++) pinv[bit_of(n)] = hist[0][n];
      case (addr[3:2])
        2'd0: for (int b = 0; b < W; b++) rv[b] = is_out(dirv, b) ? latch[b] : pinv[b];
        2'd1: rv = RB ? latch : '0;
        2'd2: rv = '0;
        default: rv = dirv;
      endcase
      if (ren) e_rdata = rv;
      if (wen) begin
        case (addr[3:2])
          2'd0: latch = wdata;
          2'd1: latch = latch | wdata;
          2'd2: latch = latch & ~wdata;
          default: dirv = wdata;
        endcase
      end
      void'(hist.pop_front());
      hist.push_back(pad);
    end
  end

  always @* begin
    for (int n = 0; n < W; n++) begin
      e_oe[n]  = is_out(dirv, bit_of(n));
      e_out[n] = e_oe[n] & latch[bit_of(n)];
    end
  end
endmodule

module test_mmio_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wen = 1'b0, ren = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pad_a = '0;
  logic [7:0]  pad_b = '0;
  logic [31:0] rd_a, oe_a, out_a, er_a, eo_a, ev_a;
  logic [7:0]  rd_b, oe_b, out_b, er_b, eo_b, ev_b;
  int          checks = 0, errors = 0;
  bit          started = 1'b0;
  string       cur_req = "R1";

  always #4 clk = ~clk;

  mmio_gpio_ctrl i_mmio_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata),
    .bus_ren(ren), .bus_rdata(rd_a), .pad_in(pad_a), .pad_oe(oe_a), .pad_out(out_a));

  mmio_gpio_ctrl #(.WIDTH(8), .ADDR_W(4), .DIR_INVERT(1'b1), .REVERSE_BITS(1'b1),
                   .SET_READBACK(1'b1)) i_mmio_gpio_ctrl_alt (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata[7:0]),
    .bus_ren(ren), .bus_rdata(rd_b), .pad_in(pad_b), .pad_oe(oe_b), .pad_out(out_b));

  gpio_ref_model #(.W(32)) m_a (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wen(wen), .ren(ren), .wdata(wdata),
    .pad(pad_a), .e_rdata(er_a), .e_oe(eo_a), .e_out(ev_a));

  gpio_ref_model #(.W(8), .INV(1'b1), .REV(1'b1), .RB(1'b1)) m_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wen(wen), .ren(ren), .wdata(wdata[7:0]),
    .pad(pad_b), .e_rdata(er_b), .e_oe(eo_b), .e_out(ev_b));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(cur_req, "model rdata", rd_a, er_a);
      chk(cur_req, "model pad_oe", oe_a, eo_a);
      chk(cur_req, "model pad_out", out_a, ev_a);
      chk(cur_req, "alt model rdata", {24'h0, rd_b}, {24'h0, er_b});
      chk(cur_req, "alt model pad_oe", {24'h0, oe_b}, {24'h0, eo_b});
      chk(cur_req, "alt model pad_out", {24'h0, out_b}, {24'h0, ev_b});
    end
  end

  task automatic op(logic [3:0] a, bit w, bit r, logic [31:0] d);
    addr = a; wen = w; ren = r; wdata = d;
    @(negedge clk);
    wen = 1'b0; ren = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk);
    started = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "reset rdata", rd_a, 32'h0);
    chk("R1", "reset pad_oe", oe_a, 32'h0);
    chk("R1", "reset pad_out", out_a, 32'h0);
    chk("R1", "alt reset pad_oe", {24'h0, oe_b}, 32'h0);

    cur_req = "R6";
    op(4'hC, 0, 1, 0);
    chk("R6", "alt dir reset readback", {24'h0, rd_b}, 32'hFF);
    chk("R5", "dir reset readback", rd_a, 32'h0);

    cur_req = "R11";
    op(4'h0, 1, 0, 32'hA5A5_3C31);
    chk("R11", "latch loaded, inputs not driven", out_a, 32'h0);

    cur_req = "R5";
    op(4'hC, 1, 0, 32'hFFFF_0000);
    chk("R5", "pad_oe after dir write", oe_a, 32'hFFFF_0000);
    chk("R2", "pad_out of loaded latch", out_a, 32'hA5A5_0000);
    chk("R6", "alt all outputs with dir 0", {24'h0, oe_b}, 32'hFF);
    chk("R9", "alt reversed pad_out", {24'h0, out_b}, 32'h8C);

    cur_req = "R3";
    op(4'h4, 1, 0, 32'h0F00_00C0);
    chk("R3", "pad_out after set", out_a, 32'hAFA5_0000);

    cur_req = "R4";
    op(4'h8, 1, 0, 32'h0100_0011);
    chk("R4", "pad_out after clear", out_a, 32'hAEA5_0000);
    chk("R9", "alt reversed after clear", {24'h0, out_b}, 32'h07);
    op(4'h8, 0, 1, 0);
    chk("R4", "clear word reads zero", rd_a, 32'h0);

    cur_req = "R8";
    op(4'h4, 0, 1, 0);
    chk("R8", "set word without readback", rd_a, 32'h0);
    chk("R8", "alt set word readback", {24'h0, rd_b}, 32'hE0);

    cur_req = "R7";
    pad_a = 32'h1234_5678; pad_b = 8'h5A;
    repeat (3) op(4'h0, 0, 0, 0);
    op(4'h0, 0, 1, 0);
    chk("R7", "data read mixes pins and latch", rd_a, 32'hAEA5_5678);
    pad_a = 32'h0000_9999;
    op(4'h0, 0, 1, 0);
    chk("R7", "sync read 1 old", rd_a, 32'hAEA5_5678);
    op(4'h0, 0, 1, 0);
    chk("R7", "sync read 2 old", rd_a, 32'hAEA5_5678);
    op(4'h0, 0, 1, 0);
    chk("R7", "sync read 3 new", rd_a, 32'hAEA5_9999);
    op(4'h0, 0, 0, 0);
    chk("R7", "rdata holds without read", rd_a, 32'hAEA5_9999);

    cur_req = "R10";
    op(4'hC, 1, 0, 32'hFFFF_FFFF);
    op(4'h0, 1, 1, 32'h1357_9BDF);
    chk("R10", "read with write sees old latch", rd_a, 32'hAEA5_3CE0);
    op(4'h0, 0, 1, 0);
    chk("R10", "next read sees new latch", rd_a, 32'h1357_9BDF);

    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      pad_a = $urandom; pad_b = 8'($urandom);
      op(4'($urandom_range(0, 3) * 4), 1'($urandom), 1'($urandom), $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule